// File: doc/BRIEF.md
# DDR Bank Open/Recovery State Tracker

This block sits on the controller side of a four-bank DDR SDRAM interface. It tracks which banks hold an open row and which banks may accept a new row activation. It watches a command bus that is already registered. Each cycle it receives a 3-bit command code, a bank select and the auto-all flag carried on address bit 10. Each bank runs a small state machine of its own with three states. `BK_IDLE` means the bank is closed and may be activated. `BK_OPEN` means a row is active. `BK_RECOVER` means the bank was precharged and its row-precharge recovery window (tRP) is still counting down.

The named transitions are:
- `activate`: `BK_IDLE` to `BK_OPEN`.
- `close`: `BK_OPEN` or `BK_IDLE` to `BK_RECOVER` on a precharge. The bank goes straight to `BK_IDLE` when tRP is one cycle.
- `rearm`: `BK_RECOVER` to `BK_RECOVER` on a repeated precharge, which reloads the counter.
- `expire`: `BK_RECOVER` to `BK_IDLE` when the countdown ends.

An activate aimed at a bank that is still recovering is a protocol error. So is a read or write aimed at a bank that is not open. Either error raises a registered one-cycle violation strobe. The controller uses the per-bank open and ready flags to schedule commands, and uses the strobe as a sanity monitor.

Top module: `ddr_bank_tracker`

## Requirements
- R1: During and after reset, with only NOPs presented, every bank reads closed (`bank_open_o`=0), every bank reads ready (`bank_ready_o`=1) and `violation_o` is 0.
- R2: An ACTIVATE (cmd 3'b001) sampled at a clock edge for a ready bank makes that bank's `bank_open_o` 1 and its `bank_ready_o` 0 immediately after that edge, with no violation.
- R3: A PRECHARGE (cmd 3'b100) with `a10_i`=1 closes every bank whatever `ba_i` holds, and every bank then starts its tRP recovery.
- R4: A PRECHARGE with `a10_i`=0 closes and starts recovery only in the bank numbered by `ba_i`; the other banks keep their state and their countdowns.
- R5: Take a PRECHARGE sampled at edge k. The affected banks show `bank_ready_o`=0 from just after edge k until just after edge k+TRP_CYCLES-1, and show 1 from then on. An ACTIVATE sampled TRP_CYCLES edges after the precharge is therefore legal, and one sampled earlier is not.
- R6: An ACTIVATE to a bank in recovery raises `violation_o` for exactly the one cycle after the edge where it was sampled, and leaves the bank closed with its countdown running.
- R7: A READ (3'b010) or WRITE (3'b011) to a bank that is not open raises `violation_o` for one cycle and changes no bank state.
- R8: A READ or WRITE to an open bank produces no violation and changes no bank state.
- R9: A PRECHARGE to a bank that is already idle, or already recovering, is legal (no violation) and restarts that bank's full tRP countdown.
- R10: NOP (3'b000) and the unused codes 3'b101 to 3'b111 change no state and raise no violation.
- R11: An ACTIVATE to a bank that is already open changes nothing and raises no violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Registered command code (NOP, ACTIVATE, READ, WRITE, PRECHARGE) |
| ba_i | input | 2 | Bank select; ignored by an all-bank precharge |
| a10_i | input | 1 | Address bit 10; 1 selects all-bank precharge |
| bank_open_o | output | 4 | Per-bank flag: row open |
| bank_ready_o | output | 4 | Per-bank flag: closed and recovery finished |
| violation_o | output | 1 | One-cycle strobe, one cycle after an illegal command |

## Verification
The hardest point to reach from the ports is the last cycle of a recovery window. There an activate must be rejected, yet one cycle later the same activate must be accepted. This has to hold while other banks are partway through their own countdowns, and while a repeated precharge has just rearmed the counter. The bench reaches this point in three ways. Directed sequences place activates at every offset after single-bank and all-bank precharges. An exhaustive sweep covers every command code, bank and bit-10 value. A long pseudo-random command stream is compared each cycle against an arithmetic per-bank model of open flags and remaining recovery cycles.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'b000,
        CMD_ACT = 3'b001,
        CMD_RD  = 3'b010,
        CMD_WR  = 3'b011,
        CMD_PRE = 3'b100
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'b00,
        BK_OPEN    = 2'b01,
        BK_RECOVER = 2'b10
    } bank_state_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode #(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input  logic [2:0]           cmd_i,
    input  logic [BA_W-1:0]      ba_i,
    input  logic                 a10_i,
    output logic [NUM_BANKS-1:0] act_sel_o,
    output logic [NUM_BANKS-1:0] rw_sel_o,
    output logic [NUM_BANKS-1:0] pre_sel_o
);
    import ddr_trk_pkg::*;

    logic [NUM_BANKS-1:0] bank_hot;

    always_comb begin
        bank_hot  = NUM_BANKS'(1) << ba_i;
        act_sel_o = '0;
        rw_sel_o  = '0;
        pre_sel_o = '0;
        unique case (cmd_i)
            CMD_ACT: act_sel_o = bank_hot;
            CMD_RD,
            CMD_WR:  rw_sel_o  = bank_hot;
            CMD_PRE: pre_sel_o = a10_i ? {NUM_BANKS{1'b1}} : bank_hot;
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm #(
    parameter int TRP_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic rw_i,
    input  logic pre_i,
    output logic open_o,
    output logic ready_o,
    output logic viol_o
);
    import ddr_trk_pkg::*;

    localparam int CW = (TRP_CYCLES > 1) ? $clog2(TRP_CYCLES + 1) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(TRP_CYCLES - 1);
    localparam bank_state_e  AFTER_PRE = (TRP_CYCLES > 1) ? BK_RECOVER : BK_IDLE;

    bank_state_e    state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BK_IDLE: begin
                if (pre_i) begin            // close
                    state_d = AFTER_PRE;
                    cnt_d   = RELOAD;
                end else if (act_i) begin   // activate
                    state_d = BK_OPEN;
                end
            end
            BK_OPEN: begin
                if (pre_i) begin            // close
                    state_d = AFTER_PRE;
                    cnt_d   = RELOAD;
                end
            end
            BK_RECOVER: begin
                if (pre_i) begin            // rearm
                    cnt_d   = RELOAD;
                end else if (cnt_q <= CW'(1)) begin // expire
                    state_d = BK_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q - CW'(1);
                end
            end
            default: begin
                state_d = BK_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        open_o  = (state_q == BK_OPEN);
        ready_o = (state_q == BK_IDLE);
        viol_o  = (act_i && state_q == BK_RECOVER) ||
                  (rw_i  && state_q != BK_OPEN);
    end
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
    parameter  int NUM_BANKS  = 4,
    parameter  int TRP_CYCLES = 3,
    localparam int BA_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cmd_i,
    input  logic [BA_W-1:0]      ba_i,
    input  logic                 a10_i,
    output logic [NUM_BANKS-1:0] bank_open_o,
    output logic [NUM_BANKS-1:0] bank_ready_o,
    output logic                 violation_o
);
    logic [NUM_BANKS-1:0] act_sel, rw_sel, pre_sel, bank_viol;

    ddr_cmd_decode #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_dec (
        .cmd_i     (cmd_i),
        .ba_i      (ba_i),
        .a10_i     (a10_i),
        .act_sel_o (act_sel),
        .rw_sel_o  (rw_sel),
        .pre_sel_o (pre_sel)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ddr_bank_fsm #(.TRP_CYCLES(TRP_CYCLES)) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_i   (act_sel[g]),
            .rw_i    (rw_sel[g]),
            .pre_i   (pre_sel[g]),
            .open_o  (bank_open_o[g]),
            .ready_o (bank_ready_o[g]),
            .viol_o  (bank_viol[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) violation_o <= 1'b0;
        else        violation_o <= |bank_viol;
    end
endmodule

// File: rtl/ddr_bank_tracker_chk.sv
module ddr_bank_tracker_chk #(
    parameter  int NUM_BANKS  = 4,
    parameter  int TRP_CYCLES = 3,
    localparam int BA_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           cmd_i,
    input logic [BA_W-1:0]      ba_i,
    input logic                 a10_i,
    input logic [NUM_BANKS-1:0] bank_open_o,
    input logic [NUM_BANKS-1:0] bank_ready_o,
    input logic                 violation_o
);
    a_r3_all_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'b100 && a10_i) |=> (bank_open_o == '0));

    a_r4_one_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'b100 && !a10_i) |=>
        (bank_open_o == ($past(bank_open_o) & ~(NUM_BANKS'(1) << $past(ba_i)))));

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_open_o & bank_ready_o) == '0);

    a_r5_pre_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (TRP_CYCLES > 1 && cmd_i == 3'b100 && a10_i) |=> (bank_ready_o == '0));

    a_r6_act_busy_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'b001 && !bank_open_o[ba_i] && !bank_ready_o[ba_i]) |=> violation_o);

    a_r7_rw_closed_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == 3'b010 || cmd_i == 3'b011) && !bank_open_o[ba_i]) |=> violation_o);

    a_r10_quiet_no_viol: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_i == 3'b001 || cmd_i == 3'b010 || cmd_i == 3'b011) |=> !violation_o);

    a_r10_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'b000 || cmd_i > 3'b100) |=> $stable(bank_open_o));
endmodule

bind ddr_bank_tracker ddr_bank_tracker_chk #(
    .NUM_BANKS  (NUM_BANKS),
    .TRP_CYCLES (TRP_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_i        (cmd_i),
    .ba_i         (ba_i),
    .a10_i        (a10_i),
    .bank_open_o  (bank_open_o),
    .bank_ready_o (bank_ready_o),
    .violation_o  (violation_o)
);

// File: tb/ddr_bank_tracker_bench.sv
module ddr_bank_tracker_bench;
    localparam int NB  = 4;
    localparam int TRP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_i = 3'b000;
    logic [1:0] ba_i = 2'b00;
    logic       a10_i = 1'b0;
    logic [NB-1:0] bank_open_o, bank_ready_o;
    logic       violation_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    bit mopen [NB];
    int mcnt  [NB];

    ddr_bank_tracker #(.NUM_BANKS(NB), .TRP_CYCLES(TRP)) u_ddr_bank_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd_i),
        .ba_i         (ba_i),
        .a10_i        (a10_i),
        .bank_open_o  (bank_open_o),
        .bank_ready_o (bank_ready_o),
        .violation_o  (violation_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag, bit exp_viol);
        logic [NB-1:0] eo, er;
        for (int i = 0; i < NB; i++) begin
            eo[i] = mopen[i];
            er[i] = !mopen[i] && mcnt[i] == 0;
        end
        check(tag, "open",  int'(bank_open_o),  int'(eo));
        check(tag, "ready", int'(bank_ready_o), int'(er));
        check(tag, "viol",  int'(violation_o),  int'(exp_viol));
    endtask

    // issue one command, advance the model, check just after the edge
    task automatic issue(logic [2:0] c, logic [1:0] b, logic a, string tag);
        bit v = 1'b0;
        cmd_i = c; ba_i = b; a10_i = a;
        for (int i = 0; i < NB; i++) begin
            bit hit = (i == int'(b));
            bit pre = (c == 3'b100) && (a || hit);
            if (pre) begin
                mopen[i] = 1'b0;
                mcnt[i]  = TRP - 1;
            end else begin
                if (c == 3'b001 && hit) begin
                    if (!mopen[i] && mcnt[i] != 0) v = 1'b1;
                    else if (!mopen[i])            mopen[i] = 1'b1;
                end
                if ((c == 3'b010 || c == 3'b011) && hit && !mopen[i]) v = 1'b1;
                if (mcnt[i] > 0) mcnt[i]--;
            end
        end
        @(posedge clk); #1;
        cmd_i = 3'b000;
        check_all(tag, v);
    endtask

    function automatic string tag_of(logic [2:0] c, logic a);
        case (c)
            3'b001:         return "R2/R6/R11";
            3'b010, 3'b011: return "R7/R8";
            3'b100:         return a ? "R3" : "R4";
            default:        return "R10";
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < NB; i++) begin mopen[i] = 1'b0; mcnt[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired tests=%0d", tests);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();
        check_all("R1", 1'b0);
        issue(3'b000, 2'd0, 1'b0, "R1");

        // R2: activate every bank; R11 re-activate
        for (int b = 0; b < NB; b++) issue(3'b001, 2'(b), 1'b0, "R2");
        issue(3'b001, 2'd2, 1'b0, "R11");
        // R8 read/write to open banks
        issue(3'b010, 2'd1, 1'b0, "R8");
        issue(3'b011, 2'd3, 1'b0, "R8");
        // R4 single-bank precharge, ba honored
        issue(3'b100, 2'd1, 1'b0, "R4");
        // R7 read to the closed bank
        issue(3'b010, 2'd1, 1'b0, "R7");
        // R6 activate during recovery, then R5 exact ready edge
        issue(3'b001, 2'd1, 1'b0, "R6");
        issue(3'b000, 2'd0, 1'b0, "R5");
        issue(3'b001, 2'd1, 1'b0, "R5");
        check("R5", "bank1 open after legal act", int'(bank_open_o[1]), 1);
        // R3 all-bank precharge, ba ignored
        issue(3'b100, 2'd2, 1'b1, "R3");
        check("R3", "all closed", int'(bank_open_o), 0);
        issue(3'b011, 2'd0, 1'b0, "R7");
        issue(3'b000, 2'd0, 1'b0, "R5");
        check("R5", "all ready after TRP", int'(bank_ready_o), 4'hF);
        // R9 precharge idle bank, then rearm mid-recovery
        issue(3'b100, 2'd0, 1'b0, "R9");
        issue(3'b100, 2'd0, 1'b0, "R9");
        issue(3'b001, 2'd0, 1'b0, "R9");
        issue(3'b000, 2'd0, 1'b0, "R9");
        issue(3'b001, 2'd0, 1'b0, "R9");
        check("R9", "bank0 open after rearm window", int'(bank_open_o[0]), 1);
        // R10 unused codes
        for (int c = 5; c < 8; c++) issue(3'(c), 2'd0, 1'b1, "R10");

        // exhaustive sweep: every code, bank and bit-10 value
        for (int c = 0; c < 8; c++)
            for (int b = 0; b < NB; b++)
                for (int a = 0; a < 2; a++) begin
                    issue(3'(c), 2'(b), 1'(a), tag_of(3'(c), 1'(a)));
                    issue(3'b001, 2'(b), 1'b0, "R2/R6/R11");
                end

        // pseudo-random stream
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] c;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c = lfsr[2:0];
            if (c == 3'b100 && lfsr[5]) c = 3'b001;
            issue(c, lfsr[4:3], lfsr[6] & lfsr[7], tag_of(c, lfsr[6] & lfsr[7]));
        end

        // reset mid-activity returns to R1 state
        issue(3'b001, 2'd3, 1'b0, "R2");
        do_reset();
        check_all("R1", 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule